// File: doc/BRIEF.md
# Multiplexed LCD Waveform Sequencer

This block turns a stored picture of 105 pixel bits plus a handful of control fields into the drive level codes for a 1/3-duty multiplexed liquid-crystal panel. The panel has three common lines and 35 segment lines. Every output is a 2-bit code that names one of four rail levels: 0 = ground, 1 = one third, 2 = two thirds, 3 = full supply. An analog switch bank outside the block turns each code into a voltage. The sequencer steps through the three common phases at a rate set by an oscillator tick. It alternates drive polarity so that no pixel carries a DC component.

At run time a controller picks between one-half and one-third bias. It can also blank every segment while the commons keep scanning, or enter a power-save state that stops the scan. Up to eight of the leading segment pins can be taken over as static general-purpose outputs. An external active-low inhibit input forces the whole panel dark.

Top module: `lcd_wave_seq`

## Requirements
- R1: After synchronous reset the scan is at the start of the COM1 phase in positive polarity. With one-third bias, no blanking, power save off and inhibit high, `com_lvl` reads COM1=3, COM2=1, COM3=1.
- R2: Only clock cycles with `osc_tick` high advance the scan. A frame is 384 ticks, made of phases COM1, COM2 and COM3 of 128 ticks each. Within each phase the first 64 ticks are positive polarity and the last 64 negative.
- R3: With one-third bias (`bias_half`=0), the selected common is at 3 in positive polarity and 0 in negative. An unselected common is at 1 in positive polarity and 2 in negative.
- R4: With one-third bias, a lit segment is at 0 in positive polarity and 3 in negative. An unlit segment is at 2 in positive polarity and 1 in negative.
- R5: With one-half bias (`bias_half`=1), the selected common is at 3 or 0 and an unselected common is always at 1. A lit segment is at 0 in positive polarity and 3 in negative. An unlit segment is at 3 in positive polarity and 0 in negative. Code 2 never appears.
- R6: Segment pin n (1..35, bus field `seg_lvl[2n-1:2n-2]`) shows `disp_bits[3n-3]` during COM1, `disp_bits[3n-2]` during COM2 and `disp_bits[3n-1]` during COM3. Common m uses field `com_lvl[2m-1:2m-2]`.
- R7: With `seg_blank`=1, every segment that is not a port drives the unlit waveform. The commons are unchanged.
- R8: With `power_save`=1, all commons and all non-port segments are at 0. The scan position is held at its start, so the first tick after release continues from the COM1 positive position.
- R9: A `port_code` of N turns pins 1..min(N,8) into static outputs. Such a pin drives 3 when `disp_bits[3n-3]` is 1 and 0 otherwise, whatever the bias, blanking, power-save state or scan position. Codes 9..15 act as 8.
- R10: With `inhibit_n`=0, every common, segment and port pin is at 0. The scan keeps advancing on ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_tick | input | 1 | One-cycle pulse at the oscillator rate |
| disp_bits | input | 105 | Pixel bits, three per segment pin |
| port_code | input | 4 | Count of leading pins used as static outputs |
| bias_half | input | 1 | 1 selects one-half bias, 0 one-third bias |
| seg_blank | input | 1 | 1 forces segments to the unlit waveform |
| power_save | input | 1 | 1 stops the scan and grounds the panel drive |
| inhibit_n | input | 1 | 0 forces every output to ground |
| com_lvl | output | 6 | Level codes of the three commons, 2 bits each |
| seg_lvl | output | 70 | Level codes of the 35 segment pins, 2 bits each |

## Verification
The hardest situation to reach is a change of drive state at a scan boundary: the polarity flip at tick 64 of a phase, the phase change at tick 128, and the frame wrap at 384. In particular, power save can end at any point while a frame is partly done. The stimulus walks more than a full frame tick by tick in each bias mode. It then mixes long random stretches of sparse ticks with randomly placed power-save pulses and inhibit pulses, so that release happens at many scan positions. Each pixel mapping is proven with one-hot picture patterns.

// File: rtl/lcd_wave_pkg.sv
// Shared level codes and the level selection rules of the sequencer.
// Assumes an external switch bank maps code 0..3 onto ground, 1/3, 2/3
// and full supply; in half bias both middle taps are tied together.
package lcd_wave_pkg;

    typedef logic [1:0] lvl_t;

    localparam lvl_t LVL_GND  = 2'd0;
    localparam lvl_t LVL_LOW  = 2'd1;
    localparam lvl_t LVL_HIGH = 2'd2;
    localparam lvl_t LVL_FULL = 2'd3;

    // Level of a common line for the given selection, polarity and bias.
    function automatic lvl_t com_level(input logic sel, input logic neg,
                                       input logic half);
        lvl_t r;
        if (sel)       r = neg ? LVL_GND : LVL_FULL;
        else if (half) r = LVL_LOW;
        else           r = neg ? LVL_HIGH : LVL_LOW;
        return r;
    endfunction

    // Level of a segment line for the given pixel state, polarity and bias.
    function automatic lvl_t seg_level(input logic lit, input logic neg,
                                       input logic half);
        lvl_t r;
        if (half)      r = (lit ^ neg) ? LVL_GND : LVL_FULL;
        else if (neg)  r = lit ? LVL_FULL : LVL_LOW;
        else           r = lit ? LVL_GND : LVL_HIGH;
        return r;
    endfunction

endpackage

// File: rtl/lcd_frame_timer.sv
// Scan position counter. Divides the oscillator tick into NCOM phases of
// DIV/NCOM ticks each, with the second half of each phase in negative
// polarity. Assumes DIV is a multiple of 2*NCOM. Held at the start while
// halt is high.
module lcd_frame_timer #(
    parameter int DIV  = 384,
    parameter int NCOM = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            halt,
    output logic [NCOM-1:0] phase_sel,
    output logic            neg
);
    localparam int PH   = DIV / NCOM;
    localparam int HALF = PH / 2;
    localparam int SW   = (PH > 1) ? $clog2(PH) : 1;
    localparam int PHW  = (NCOM > 1) ? $clog2(NCOM) : 1;

    logic [SW-1:0]  sub_q;
    logic [PHW-1:0] ph_q;

    // Advance the tick-within-phase and phase counters on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || halt) begin
            sub_q <= '0;
            ph_q  <= '0;
        end else if (tick) begin
            if (sub_q == SW'(PH - 1)) begin
                sub_q <= '0;
                ph_q  <= (ph_q == PHW'(NCOM - 1)) ? '0 : ph_q + PHW'(1);
            end else begin
                sub_q <= sub_q + SW'(1);
            end
        end
    end

    // Decode the phase index into a one-hot common selection.
    for (genvar j = 0; j < NCOM; j++) begin : g_sel
        assign phase_sel[j] = (ph_q == PHW'(j));
    end

    assign neg = (sub_q >= SW'(HALF));

endmodule

// File: rtl/lcd_port_map.sv
// Thermometer decode of the port count into a per-pin port mask. Counts
// beyond NPORT saturate naturally. All pins revert to segments while
// the enable is low.
module lcd_port_map #(
    parameter int NPORT = 8,
    parameter int PCW   = 4
) (
    input  logic [PCW-1:0]   port_code,
    input  logic             enable,
    output logic [NPORT-1:0] port_mask
);
    // Pin i is a port when the count exceeds its index.
    for (genvar i = 0; i < NPORT; i++) begin : g_mask
        assign port_mask[i] = enable && (port_code > PCW'(i));
    end
endmodule

// File: rtl/lcd_com_driver.sv
// Level codes of the common lines from the scan position and bias.
// Assumes phase_sel is one-hot; dark forces ground on every line.
module lcd_com_driver
    import lcd_wave_pkg::*;
#(
    parameter int NCOM = 3
) (
    input  logic [NCOM-1:0]   phase_sel,
    input  logic              neg,
    input  logic              half,
    input  logic              dark,
    output logic [2*NCOM-1:0] com_lvl
);
    // One level selector per common line.
    for (genvar j = 0; j < NCOM; j++) begin : g_com
        assign com_lvl[2*j +: 2] = dark ? LVL_GND
                                        : com_level(phase_sel[j], neg, half);
    end
endmodule

// File: rtl/lcd_seg_driver.sv
// Level codes of the segment lines. Each pin owns NCOM consecutive pixel
// bits (lowest bit for the first common). The leading NPORT pins can be
// switched to static outputs driven from their first pixel bit.
module lcd_seg_driver
    import lcd_wave_pkg::*;
#(
    parameter int NSEG  = 35,
    parameter int NCOM  = 3,
    parameter int NPORT = 8
) (
    input  logic [NSEG*NCOM-1:0] disp_bits,
    input  logic [NCOM-1:0]      phase_sel,
    input  logic                 neg,
    input  logic                 half,
    input  logic                 blank,
    input  logic                 dark,
    input  logic [NPORT-1:0]     port_mask,
    output logic [2*NSEG-1:0]    seg_lvl
);
    // One waveform selector per segment pin, with a port mux on shared pins.
    for (genvar i = 0; i < NSEG; i++) begin : g_seg
        logic [NCOM-1:0] px;
        logic            lit;
        lvl_t            wave;
        assign px   = disp_bits[i*NCOM +: NCOM];
        assign lit  = (|(px & phase_sel)) && !blank;
        assign wave = dark ? LVL_GND : seg_level(lit, neg, half);
        if (i < NPORT) begin : g_shared
            assign seg_lvl[2*i +: 2] = port_mask[i]
                                     ? (px[0] ? LVL_FULL : LVL_GND) : wave;
        end else begin : g_plain
            assign seg_lvl[2*i +: 2] = wave;
        end
    end
endmodule

// File: rtl/lcd_wave_seq.sv
// Top of the multiplexed LCD waveform sequencer. Combines the scan timer,
// common and segment level selection and the port mapping. Outputs are a
// combinational decode of the scan registers and the control inputs.
// Assumes osc_tick is a single-cycle pulse synchronous to clk.
module lcd_wave_seq #(
    parameter int NSEG  = 35,
    parameter int NCOM  = 3,
    parameter int NPORT = 8,
    parameter int DIV   = 384,
    parameter int PCW   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 osc_tick,
    input  logic [NSEG*NCOM-1:0] disp_bits,
    input  logic [PCW-1:0]       port_code,
    input  logic                 bias_half,
    input  logic                 seg_blank,
    input  logic                 power_save,
    input  logic                 inhibit_n,
    output logic [2*NCOM-1:0]    com_lvl,
    output logic [2*NSEG-1:0]    seg_lvl
);
    logic [NCOM-1:0]  phase_sel;
    logic             neg;
    logic [NPORT-1:0] port_mask;
    logic             dark;

    assign dark = power_save || !inhibit_n;

    lcd_frame_timer #(.DIV(DIV), .NCOM(NCOM)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (osc_tick),
        .halt      (power_save),
        .phase_sel (phase_sel),
        .neg       (neg)
    );

    lcd_port_map #(.NPORT(NPORT), .PCW(PCW)) u_ports (
        .port_code (port_code),
        .enable    (inhibit_n),
        .port_mask (port_mask)
    );

    lcd_com_driver #(.NCOM(NCOM)) u_com (
        .phase_sel (phase_sel),
        .neg       (neg),
        .half      (bias_half),
        .dark      (dark),
        .com_lvl   (com_lvl)
    );

    lcd_seg_driver #(.NSEG(NSEG), .NCOM(NCOM), .NPORT(NPORT)) u_seg (
        .disp_bits (disp_bits),
        .phase_sel (phase_sel),
        .neg       (neg),
        .half      (bias_half),
        .blank     (seg_blank),
        .dark      (dark),
        .port_mask (port_mask),
        .seg_lvl   (seg_lvl)
    );

endmodule

// File: rtl/lcd_wave_seq_checker.sv
// Property checker for the sequencer, attached to every instance by bind.
module lcd_wave_seq_checker #(
    parameter int NSEG  = 35,
    parameter int NCOM  = 3,
    parameter int NPORT = 8,
    parameter int PCW   = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 osc_tick,
    input logic [PCW-1:0]       port_code,
    input logic                 bias_half,
    input logic                 power_save,
    input logic                 inhibit_n,
    input logic [2*NCOM-1:0]    com_lvl,
    input logic [2*NSEG-1:0]    seg_lvl
);
    logic [NCOM-1:0] com_extreme;
    logic            any_upper_mid;

    // Flag commons at a rail and any output carrying the upper middle code.
    always_comb begin
        any_upper_mid = 1'b0;
        for (int j = 0; j < NCOM; j++) begin
            com_extreme[j] = (com_lvl[2*j +: 2] == 2'd0) || (com_lvl[2*j +: 2] == 2'd3);
            if (com_lvl[2*j +: 2] == 2'd2) any_upper_mid = 1'b1;
        end
        for (int i = 0; i < NSEG; i++) begin
            if (seg_lvl[2*i +: 2] == 2'd2) any_upper_mid = 1'b1;
        end
    end

    // R2: without a tick the commons hold when their controls hold
    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_tick && !power_save) |=>
        (!$stable(bias_half) || !$stable(inhibit_n) || !$stable(power_save) || $stable(com_lvl)));

    // R3: exactly one common sits at a rail while the panel is driven
    a_r3_single_selected: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit_n && !power_save) |-> ($countones(com_extreme) == 1));

    // R5: half bias never uses the upper middle code
    a_r5_no_upper_mid: assert property (@(posedge clk) disable iff (!rst_n)
        bias_half |-> !any_upper_mid);

    // R8: power save grounds commons and the unshared segments
    a_r8_save_dark: assert property (@(posedge clk) disable iff (!rst_n)
        power_save |-> (com_lvl == '0 && seg_lvl[2*NSEG-1:2*NPORT] == '0));

    // R9: with a zero port count, power save grounds every segment
    a_r9_no_ports_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (power_save && port_code == '0) |-> (seg_lvl == '0));

    // R10: inhibit grounds every output
    a_r10_inhibit_dark: assert property (@(posedge clk) disable iff (!rst_n)
        !inhibit_n |-> (com_lvl == '0 && seg_lvl == '0));

endmodule

bind lcd_wave_seq lcd_wave_seq_checker #(
    .NSEG(NSEG), .NCOM(NCOM), .NPORT(NPORT), .PCW(PCW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_tick   (osc_tick),
    .port_code  (port_code),
    .bias_half  (bias_half),
    .power_save (power_save),
    .inhibit_n  (inhibit_n),
    .com_lvl    (com_lvl),
    .seg_lvl    (seg_lvl)
);

// File: tb/lcd_wave_seq_test.sv
`timescale 1ns/1ps
module lcd_wave_seq_test;
    localparam int NSEG = 35;
    localparam int NCOM = 3;
    localparam int NB   = NSEG * NCOM;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            osc_tick = 1'b0;
    logic [NB-1:0]   disp_bits = '0;
    logic [3:0]      port_code = '0;
    logic            bias_half = 1'b0;
    logic            seg_blank = 1'b0;
    logic            power_save = 1'b0;
    logic            inhibit_n = 1'b1;
    logic [2*NCOM-1:0] com_lvl;
    logic [2*NSEG-1:0] seg_lvl;

    int tests = 0;
    int fails = 0;
    int cnt   = 0;

    always #2 clk = ~clk;

    lcd_wave_seq uut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .disp_bits(disp_bits),
        .port_code(port_code), .bias_half(bias_half), .seg_blank(seg_blank),
        .power_save(power_save), .inhibit_n(inhibit_n),
        .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

    // Expected common level from the scan position model (R3, R5, R8, R10).
    function automatic logic [1:0] exp_com(int j);
        int  ph = cnt / 128;
        bit  ng = (cnt % 128) >= 64;
        if (!inhibit_n || power_save) return 2'd0;
        if (j == ph) return ng ? 2'd0 : 2'd3;
        if (bias_half) return 2'd1;
        return ng ? 2'd2 : 2'd1;
    endfunction

    // Expected segment level (R4, R5, R6, R7, R9).
    function automatic logic [1:0] exp_seg(int n);
        int  ph = cnt / 128;
        bit  ng = (cnt % 128) >= 64;
        bit  on;
        if (inhibit_n && n < 8 && n < int'(port_code)) return disp_bits[3*n] ? 2'd3 : 2'd0;
        if (!inhibit_n || power_save) return 2'd0;
        on = disp_bits[3*n + ph] && !seg_blank;
        if (bias_half) begin
            if (ng) return on ? 2'd3 : 2'd0;
            return on ? 2'd0 : 2'd3;
        end
        if (ng) return on ? 2'd3 : 2'd1;
        return on ? 2'd0 : 2'd2;
    endfunction

    task automatic check(input string tag);
        logic [2*NCOM-1:0] ec;
        logic [2*NSEG-1:0] es;
        for (int j = 0; j < NCOM; j++) ec[2*j +: 2] = exp_com(j);
        for (int n = 0; n < NSEG; n++) es[2*n +: 2] = exp_seg(n);
        tests++;
        if (com_lvl !== ec || seg_lvl !== es) begin
            fails++;
            $display("FAIL %s pos=%0d com=%h exp=%h seg=%h exp=%h",
                     tag, cnt, com_lvl, ec, seg_lvl, es);
        end
    endtask

    // One clock: drive tick at the falling edge, update model at the rise.
    task automatic step(input logic tk);
        @(negedge clk);
        osc_tick = tk;
        @(posedge clk);
        if (!rst_n || power_save) cnt = 0;
        else if (tk) cnt = (cnt + 1) % 384;
        #1;
    endtask

    task automatic rand_disp();
        logic [127:0] r;
        r = {$urandom(), $urandom(), $urandom(), $urandom()};
        disp_bits = r[NB-1:0];
    endtask

    initial begin
        #(4ns * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rand_disp();
        for (int k = 0; k < 3; k++) step(1'b1);
        rst_n = 1'b1;
        step(1'b0);
        check("R1");

        // R3/R4: full frame walk in third bias, with a polarity edge view
        for (int k = 0; k < 400; k++) begin
            step(1'b1);
            check((k % 2) ? "R3" : "R4");
        end
        // R2: cycles without a tick hold the position
        for (int k = 0; k < 50; k++) begin
            step(k % 5 == 0);
            check("R2");
        end

        // R6: one-hot pixel patterns across every bit
        for (int b = 0; b < NB; b++) begin
            disp_bits = '0;
            disp_bits[b] = 1'b1;
            for (int k = 0; k < 3; k++) begin
                step(1'b1);
                check("R6");
            end
            for (int k = 0; k < 125; k++) step(1'b1);
        end

        // R5: half bias walk
        rand_disp();
        bias_half = 1'b1;
        for (int k = 0; k < 400; k++) begin
            step(1'b1);
            check("R5");
        end

        // R7: segment blanking in both biases
        seg_blank = 1'b1;
        for (int k = 0; k < 200; k++) begin
            if (k == 100) bias_half = 1'b0;
            step(1'b1);
            check("R7");
        end
        seg_blank = 1'b0;

        // R8: power save mid-frame, then resume from the start
        for (int k = 0; k < 170; k++) step(1'b1);
        power_save = 1'b1;
        for (int k = 0; k < 10; k++) begin
            step(1'b1);
            check("R8");
        end
        power_save = 1'b0;
        for (int k = 0; k < 70; k++) begin
            step(1'b1);
            check("R8");
        end

        // R9: every port count, with and without power save
        for (int c = 0; c < 16; c++) begin
            port_code = 4'(c);
            rand_disp();
            step(1'b1);
            check("R9");
            power_save = 1'b1;
            seg_blank = 1'(c % 2);
            step(1'b1);
            check("R9");
            power_save = 1'b0;
            seg_blank = 1'b0;
        end

        // R10: inhibit with ports active, scan keeps moving
        port_code = 4'd5;
        inhibit_n = 1'b0;
        for (int k = 0; k < 100; k++) begin
            step(1'b1);
            check("R10");
        end
        inhibit_n = 1'b1;
        step(1'b0);
        check("R10");

        // Mixed random stretch
        for (int k = 0; k < 6000; k++) begin
            if ($urandom_range(0, 99) == 0) rand_disp();
            if ($urandom_range(0, 199) == 0) port_code = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 299) == 0) bias_half = ~bias_half;
            if ($urandom_range(0, 299) == 0) seg_blank = ~seg_blank;
            power_save = ($urandom_range(0, 99) < 2);
            inhibit_n  = ($urandom_range(0, 99) > 2);
            step(1'($urandom_range(0, 2) != 0));
            check(power_save ? "R8" : (!inhibit_n ? "R10" : "R2"));
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule